// File: doc/BRIEF.md
# Interrupt flag and vector controller

This block collects interrupt events for a small 8-bit microcontroller core and turns them into a single vectored request. It watches three sources: one external interrupt pin, a group of pin-change inputs and the overflow flag of an 8-bit timer. Each pin input first passes through a two-flop synchronizer. The block then turns the external pin into either an edge event or a level request, depending on a 2-bit sense setting. Any transition on any pin-change input is latched as a pin-change event.

The latched flags, their enable bits and a timer enable bit are visible on an 8-bit I/O bus. Software clears a flag by writing a one to its bit. Every request is gated by the core's global interrupt-enable bit. The highest-priority request is presented to the core as a vector address. When the core acknowledges that vector, the flag behind it is cleared in hardware.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset every flag and enable bit is zero, all three registers read 0x00 and no request is raised.
- R2: The flag register sits at I/O address 0x3A. Bit 6 holds the external flag and bit 5 holds the pin-change flag. All other bits read as zero and ignore writes.
- R3: The timer enable register sits at 0x39 and only its bit 1 (overflow enable) is writable. The general enable register sits at 0x3B and only bits 6 (external enable) and 5 (pin-change enable) are writable. All other bits read as zero.
- R4: The sense code is an input. Code 01 sets the external flag on any edge, code 10 on a falling edge only and code 11 on a rising edge only. An edge of the other direction leaves the flag unchanged.
- R5: With sense code 00 (low level), the external flag reads zero. A request is raised while the synchronized pin is low, its enable bit is one and the global enable is one, and the request is dropped when the pin goes high.
- R6: Any transition on any of the pin-change inputs sets the pin-change flag.
- R7: A source requests only when its flag (or level), its enable bit and the global enable are all one.
- R8: The vector addresses are 0x001 for the external pin, 0x002 for pin change and 0x003 for timer overflow. When several sources request at once, the lowest address is presented.
- R9: An acknowledge in a cycle where a vector is presented clears the flag of that vector. The next pending source is then presented.
- R10: Writing a one to a flag bit clears that flag. Writing a zero leaves it unchanged.
- R11: If a hardware set event and a clear of the same flag fall in the same cycle, the flag ends up set.
- R12: A pin change driven just after a clock edge appears in the flag register after the third following rising edge and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_addr | input | 6 | I/O register address |
| io_wdata | input | 8 | I/O write data |
| io_we | input | 1 | I/O write strobe |
| io_rdata | output | 8 | I/O read data for io_addr (combinational) |
| ext_pin | input | 1 | External interrupt pin (asynchronous) |
| ext_sense_mode | input | 2 | External sense: 00 low level, 01 any edge, 10 falling, 11 rising |
| pc_pins | input | 4 | Pin-change inputs (asynchronous) |
| tmr_ovf_flag | input | 1 | Timer overflow flag from the timer |
| gie | input | 1 | Global interrupt enable from the status register |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vec | output | 9 | Vector address of the presented request |
| irq_ack | input | 1 | Core acknowledges the presented vector |

## Verification
The bench drives every sense code against both pin directions. A sense decoder with swapped edge polarity would set the flag on the wrong edge, and one that forgets level mode would show a stale external flag. It counts clock edges between a pin change and the flag to catch a missing or extra synchronizer stage. It then stacks all three sources and acknowledges them one at a time, so a wrong priority order, or an acknowledge that clears the wrong flag, shows up as a wrong vector. Finally it lines up a write-one-to-clear with a fresh pin-change event in the same cycle, where a design that lets the clear win would lose the interrupt.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

  typedef enum logic [1:0] {
    SNS_LOW  = 2'b00,
    SNS_ANY  = 2'b01,
    SNS_FALL = 2'b10,
    SNS_RISE = 2'b11
  } sense_e;

  localparam int NSRC    = 3;
  localparam int SRC_EXT = 0;
  localparam int SRC_PC  = 1;
  localparam int SRC_TMR = 2;

  // does a prev->cur transition match the chosen edge sense
  function automatic logic sense_hit(sense_e mode, logic prev, logic cur);
    case (mode)
      SNS_ANY:  return prev != cur;
      SNS_FALL: return prev & ~cur;
      SNS_RISE: return ~prev & cur;
      default:  return 1'b0;
    endcase
  endfunction

  // vector address of a source index: index 0 maps to address 1
  function automatic int src_vector(int idx);
    return idx + 1;
  endfunction

endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] cur_o,
  output logic [W-1:0] prev_o,
  output logic         hist_ok_o
);
  logic [W-1:0] meta_q, sync_q, prev_q;
  logic [1:0]   fill_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
      fill_q <= '0;
    end else begin
      meta_q <= pin_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
      if (fill_q != 2'd3) fill_q <= fill_q + 2'd1;
    end
  end

  assign cur_o     = sync_q;
  assign prev_o    = prev_q;
  assign hist_ok_o = (fill_q == 2'd3);

  // R12: once history is valid it stays valid and prev lags cur by one cycle
  p_hist_stays_r12: assert property (@(posedge clk) disable iff (!rst_n)
    hist_ok_o |=> hist_ok_o);
  p_prev_lags_r12: assert property (@(posedge clk) disable iff (!rst_n)
    hist_ok_o |-> prev_o == $past(cur_o));

endmodule

// File: rtl/irq_ext_sense.sv
module irq_ext_sense
  import irq_ctrl_pkg::*;
(
  input  sense_e mode,
  input  logic   cur,
  input  logic   prev,
  input  logic   hist_ok,
  output logic   set_evt,
  output logic   level_act
);
  assign set_evt   = hist_ok && sense_hit(mode, prev, cur);
  assign level_act = hist_ok && (mode == SNS_LOW) && !cur;

  // R5: a level-mode pin never produces an edge event
  always_comb begin
    a_level_no_edge_r5: assert (!(mode == SNS_LOW && set_evt));
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_ctrl_pkg::*;
#(
  parameter int N     = NSRC,
  parameter int VEC_W = 9
) (
  input  logic [N-1:0]     req,
  output logic [N-1:0]     grant,
  output logic             any,
  output logic [VEC_W-1:0] vec
);
  always_comb begin
    grant = '0;
    vec   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
        vec      = VEC_W'(src_vector(i));
      end
    end
  end

  assign any = |req;

  // R8: at most one source is granted, and only one that requests
  always_comb begin
    a_grant_onehot_r8: assert ($onehot0(grant));
    a_grant_in_req_r8: assert ((grant & ~req) == '0);
  end
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int PC_W   = 4,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8,
  parameter int VEC_W  = 9,
  parameter logic [ADDR_W-1:0] FLAG_ADDR  = 6'h3A,
  parameter logic [ADDR_W-1:0] TMASK_ADDR = 6'h39,
  parameter logic [ADDR_W-1:0] GMASK_ADDR = 6'h3B,
  parameter int EXT_BIT = 6,
  parameter int PC_BIT  = 5,
  parameter int OVF_BIT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [DATA_W-1:0] io_wdata,
  input  logic              io_we,
  output logic [DATA_W-1:0] io_rdata,
  input  logic              ext_pin,
  input  logic [1:0]        ext_sense_mode,
  input  logic [PC_W-1:0]   pc_pins,
  input  logic              tmr_ovf_flag,
  input  logic              gie,
  output logic              irq_req,
  output logic [VEC_W-1:0]  irq_vec,
  input  logic              irq_ack
);
  sense_e mode;
  assign mode = sense_e'(ext_sense_mode);

  // synchronizers
  logic            ext_cur, ext_prev, ext_ok;
  logic [PC_W-1:0] pc_cur, pc_prev;
  logic            pc_ok;

  irq_pin_sync #(.W(1)) u_ext_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(ext_pin),
    .cur_o(ext_cur), .prev_o(ext_prev), .hist_ok_o(ext_ok));

  irq_pin_sync #(.W(PC_W)) u_pc_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(pc_pins),
    .cur_o(pc_cur), .prev_o(pc_prev), .hist_ok_o(pc_ok));

  // named events
  logic ext_set, ext_level, pc_set;

  irq_ext_sense u_sense (
    .mode(mode), .cur(ext_cur), .prev(ext_prev), .hist_ok(ext_ok),
    .set_evt(ext_set), .level_act(ext_level));

  assign pc_set = pc_ok && ((pc_cur ^ pc_prev) != '0);

  // registers
  logic ext_flag_q, pc_flag_q, ext_en_q, pc_en_q, ovf_en_q;

  logic wr_flag, wr_gmask, wr_tmask;
  assign wr_flag  = io_we && (io_addr == FLAG_ADDR);
  assign wr_gmask = io_we && (io_addr == GMASK_ADDR);
  assign wr_tmask = io_we && (io_addr == TMASK_ADDR);

  logic [NSRC-1:0]  req_vec, grant;
  logic [VEC_W-1:0] vec;
  logic             any_req;

  logic ext_clr, pc_clr;
  assign ext_clr = (wr_flag && io_wdata[EXT_BIT]) || (irq_ack && grant[SRC_EXT]);
  assign pc_clr  = (wr_flag && io_wdata[PC_BIT])  || (irq_ack && grant[SRC_PC]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_flag_q <= 1'b0;
      pc_flag_q  <= 1'b0;
      ext_en_q   <= 1'b0;
      pc_en_q    <= 1'b0;
      ovf_en_q   <= 1'b0;
    end else begin
      if (mode == SNS_LOW)  ext_flag_q <= 1'b0;
      else if (ext_set)     ext_flag_q <= 1'b1;
      else if (ext_clr)     ext_flag_q <= 1'b0;

      if (pc_set)           pc_flag_q <= 1'b1;
      else if (pc_clr)      pc_flag_q <= 1'b0;

      if (wr_gmask) begin
        ext_en_q <= io_wdata[EXT_BIT];
        pc_en_q  <= io_wdata[PC_BIT];
      end
      if (wr_tmask) ovf_en_q <= io_wdata[OVF_BIT];
    end
  end

  logic unused_wdata;
  assign unused_wdata = &{1'b0, io_wdata};

  // read decode
  always_comb begin
    io_rdata = '0;
    if (io_addr == FLAG_ADDR) begin
      io_rdata[EXT_BIT] = ext_flag_q && (mode != SNS_LOW);
      io_rdata[PC_BIT]  = pc_flag_q;
    end else if (io_addr == GMASK_ADDR) begin
      io_rdata[EXT_BIT] = ext_en_q;
      io_rdata[PC_BIT]  = pc_en_q;
    end else if (io_addr == TMASK_ADDR) begin
      io_rdata[OVF_BIT] = ovf_en_q;
    end
  end

  // request gating and arbitration
  assign req_vec[SRC_EXT] = gie && ext_en_q && ((mode == SNS_LOW) ? ext_level : ext_flag_q);
  assign req_vec[SRC_PC]  = gie && pc_en_q && pc_flag_q;
  assign req_vec[SRC_TMR] = gie && ovf_en_q && tmr_ovf_flag;

  irq_arbiter #(.N(NSRC), .VEC_W(VEC_W)) u_arb (
    .req(req_vec), .grant(grant), .any(any_req), .vec(vec));

  assign irq_req = any_req;
  assign irq_vec = vec;

  // assertions
  p_level_flag_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == SNS_LOW) |=> !ext_flag_q);
  p_req_needs_gie_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> gie);
  p_ext_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_vec[SRC_EXT] |-> (irq_vec == VEC_W'(1)));
  p_tmr_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
    grant[SRC_TMR] |-> (!req_vec[SRC_EXT] && !req_vec[SRC_PC]));
  p_ack_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && grant[SRC_PC] && !pc_set) |=> !pc_flag_q);
  p_zero_keeps_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_flag && !io_wdata[PC_BIT] && !irq_ack && pc_flag_q) |=> pc_flag_q);
  p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    pc_set |=> pc_flag_q);

endmodule

// File: tb/irq_flag_ctrl_test.sv
`timescale 1ns/1ps
module irq_flag_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] io_addr = '0;
  logic [7:0] io_wdata = '0;
  logic       io_we = 1'b0;
  logic [7:0] io_rdata;
  logic       ext_pin = 1'b0;
  logic [1:0] ext_sense_mode = 2'b01;
  logic [3:0] pc_pins = '0;
  logic       tmr_ovf_flag = 1'b0;
  logic       gie = 1'b0;
  logic       irq_req;
  logic [8:0] irq_vec;
  logic       irq_ack = 1'b0;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_flag_ctrl uut (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
    .io_we(io_we), .io_rdata(io_rdata), .ext_pin(ext_pin),
    .ext_sense_mode(ext_sense_mode), .pc_pins(pc_pins),
    .tmr_ovf_flag(tmr_ovf_flag), .gie(gie), .irq_req(irq_req),
    .irq_vec(irq_vec), .irq_ack(irq_ack));

  // {sense[1:0], pin_before, pin_after, flag_expected}
  localparam logic [4:0] EDGE_TBL [12] = '{
    {2'b01, 1'b0, 1'b1, 1'b1},
    {2'b01, 1'b1, 1'b0, 1'b1},
    {2'b01, 1'b0, 1'b0, 1'b0},
    {2'b01, 1'b1, 1'b1, 1'b0},
    {2'b10, 1'b0, 1'b1, 1'b0},
    {2'b10, 1'b1, 1'b0, 1'b1},
    {2'b10, 1'b0, 1'b0, 1'b0},
    {2'b11, 1'b0, 1'b1, 1'b1},
    {2'b11, 1'b1, 1'b0, 1'b0},
    {2'b11, 1'b1, 1'b1, 1'b0},
    {2'b00, 1'b1, 1'b0, 1'b0},
    {2'b00, 1'b0, 1'b1, 1'b0}
  };

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic io_write(logic [5:0] a, logic [7:0] d);
    io_addr = a; io_wdata = d; io_we = 1'b1;
    step(1);
    io_we = 1'b0; io_wdata = '0;
  endtask

  task automatic io_read(logic [5:0] a, output logic [7:0] d);
    io_addr = a;
    #1;
    d = io_rdata;
  endtask

  task automatic ack_once();
    irq_ack = 1'b1;
    step(1);
    irq_ack = 1'b0;
    #1;
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    // R1 reset state
    step(2);
    io_read(6'h3A, rd); chk("R1 flags", rd, 8'h00);
    io_read(6'h39, rd); chk("R1 tmask", rd, 8'h00);
    io_read(6'h3B, rd); chk("R1 gmask", rd, 8'h00);
    chk("R1 req", irq_req, 0);
    rst_n = 1'b1;
    step(5);
    chk("R1 no req after release", irq_req, 0);

    // R3 writable bits
    io_write(6'h39, 8'hFF); io_read(6'h39, rd); chk("R3 tmask", rd, 8'h02);
    io_write(6'h3B, 8'hFF); io_read(6'h3B, rd); chk("R3 gmask", rd, 8'h60);
    io_write(6'h39, 8'h00); io_write(6'h3B, 8'h00);

    // R4 / R5 edge table
    for (int i = 0; i < 12; i++) begin
      ext_sense_mode = EDGE_TBL[i][4:3];
      ext_pin = EDGE_TBL[i][2];
      step(6);
      io_write(6'h3A, 8'h40);
      ext_pin = EDGE_TBL[i][1];
      step(3);
      io_read(6'h3A, rd);
      chk((EDGE_TBL[i][4:3] == 2'b00) ? "R5 level flag zero" : "R4 edge sense",
          rd[6], EDGE_TBL[i][0]);
    end

    // R12 latency
    ext_sense_mode = 2'b11; ext_pin = 1'b0;
    step(6);
    io_write(6'h3A, 8'h40);
    ext_pin = 1'b1;
    step(2); io_read(6'h3A, rd); chk("R12 not yet after 2 edges", rd[6], 0);
    step(1); io_read(6'h3A, rd); chk("R12 set after 3 edges", rd[6], 1);

    // R6 pin change, R2 read layout and ignored bits, R10 w1c
    pc_pins[2] = 1'b1;
    step(3);
    io_read(6'h3A, rd); chk("R6 pc flag and R2 layout", rd, 8'h60);
    io_write(6'h3A, 8'h9F); io_read(6'h3A, rd); chk("R2 other bits ignored, R10 zero keeps", rd, 8'h60);
    io_write(6'h3A, 8'h20); io_read(6'h3A, rd); chk("R10 clear pc only", rd, 8'h40);
    pc_pins[3] = 1'b1;
    step(3);
    io_read(6'h3A, rd); chk("R6 other pin", rd[5], 1);
    io_write(6'h3A, 8'h20);

    // R7 gating
    io_write(6'h3B, 8'h40);
    #1; chk("R7 no gie no req", irq_req, 0);
    gie = 1'b1; #1;
    chk("R7 req with all three", irq_req, 1);
    chk("R8 ext vector", irq_vec, 9'h001);
    io_write(6'h3B, 8'h00); #1;
    chk("R7 disabled no req", irq_req, 0);

    // R8 / R9 priority and acknowledge
    io_write(6'h3B, 8'h60); io_write(6'h39, 8'h02);
    tmr_ovf_flag = 1'b1;
    pc_pins[0] = 1'b1;
    step(3); #1;
    chk("R8 ext wins", irq_vec, 9'h001);
    ack_once();
    chk("R9 pc next", irq_vec, 9'h002);
    io_read(6'h3A, rd); chk("R9 ext flag cleared", rd, 8'h20);
    ack_once();
    chk("R9 timer last", irq_vec, 9'h003);
    io_read(6'h3A, rd); chk("R9 pc flag cleared", rd, 8'h00);
    tmr_ovf_flag = 1'b0; #1;
    chk("R7 timer flag low", irq_req, 0);

    // R11 set wins over clear
    pc_pins[1] = 1'b1;
    step(2);
    io_write(6'h3A, 8'h20);
    io_read(6'h3A, rd); chk("R11 set beats w1c", rd[5], 1);
    io_write(6'h3A, 8'h20);
    io_read(6'h3A, rd); chk("R10 later w1c clears", rd[5], 0);

    // R5 level request
    io_write(6'h3B, 8'h40); io_write(6'h39, 8'h00);
    ext_sense_mode = 2'b00; ext_pin = 1'b1;
    step(4); #1;
    chk("R5 pin high no req", irq_req, 0);
    ext_pin = 1'b0;
    step(2); #1;
    chk("R5 pin low req", irq_req, 1);
    chk("R5 level vector", irq_vec, 9'h001);
    io_read(6'h3A, rd); chk("R5 flag reads zero", rd[6], 0);
    ext_pin = 1'b1;
    step(2); #1;
    chk("R5 pin high drops req", irq_req, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule